// File: doc/BRIEF.md
# Three-Format Instruction Decoder

This block turns one 32-bit instruction word into a set of decoded control fields for a small processor core. The top three bits pick one of three layouts. One layout carries control-flow and stack-pointer setup with a 24-bit immediate. One carries two 8-bit register operands and a 13-bit opcode for arithmetic, data movement and stack operations. The last carries a register index and a 16-bit half-word immediate.

The decoder is purely combinational. The fetch stage drives `instrWord` and the execute stage reads the outputs in the same cycle. The decoder reports what to do (action kind, branch condition, ALU operation), where operands come from and go to (three addressing modes and three register indices), and an immediate value. Any encoding it does not know raises `illegal` and leaves every other output at zero. Executing the operation is the job of later stages.

Top module: `instr_decoder`

## Requirements
- R1: Format field `instrWord[31:29]`=0 with opcode `instrWord[28:24]`: 0x00 gives action NOP (0). 0x10 gives action RET (3). 0x0F gives action MOVE (4) with src1Mode IMM (3), dstMode STACKPTR (6) and immValue = `instrWord[23:0]`.
- R2: In format 0, opcodes 0x01–0x05 give action JUMP (1) and 0x11–0x15 give action CALL (2). branchCond is the opcode's low nibble minus one, so the encodings are 0 always, 1 zero, 2 not-zero, 3 carry, 4 not-carry. src1Mode is IMM (3) and immValue = `instrWord[23:0]`.
- R3: Format 1 (`[31:29]`=1) reads opcode `[28:16]`, operand A `[15:8]` and operand B `[7:0]`. The two-source ALU ops map to action ALU (5) with both sources REG (1) = A and B, and the destination REG = B. The opcode-to-aluOp pairs are add 0x00→0, sub 0x01→1, compare 0x04→4, fdiv 0x0A→5, fmul 0x0B→6, fadd 0x0C→7 and fsub 0x0D→8.
- R4: The one-source format 1 ALU ops give action ALU with src1 REG = A, src2Mode NONE (0), src2Idx 0 and destination REG = A. The opcode-to-aluOp pairs are shift-left 0x02→2, shift-right 0x03→3, sine 0x0E→9, cosine 0x0F→10, decrement 0x10→11 and increment 0x11→12.
- R5: Format 1 opcode 0x05 gives HALT (8) with all modes NONE. Opcode 0x06 gives PUSH (6) with src1 REG = A. Opcode 0x07 gives POP (7) with destination REG = A.
- R6: Format 1 opcode 0x12 gives MOVE with src1 REG = A and destination REG = B. Opcode 0x08 (load) gives MOVE with src1 REG = A, src2 IND (2) = B and destination REG = B. Opcode 0x09 (store) gives MOVE with src1 REG = A, src2 REG = B and destination IND = B.
- R7: Format 2 (`[31:29]`=2) with opcode `[28:24]`=0 gives MOVE with src1 IMM, dstMode LOW (4), dstIdx = `[23:16]` and immValue = the zero-extended `[15:0]`. Opcode 1 gives the same fields with dstMode HIGH (5).
- R8: A format field of 3 to 7 raises `illegal`.
- R9: An undefined opcode in format 0, 1 or 2 raises `illegal`, and this includes a format 1 opcode with any of the bits `[28:21]` set. Whenever `illegal` is high, every other output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instrWord | input | 32 | Instruction word to decode |
| actionKind | output | 4 | Action: 0 NOP, 1 JUMP, 2 CALL, 3 RET, 4 MOVE, 5 ALU, 6 PUSH, 7 POP, 8 HALT |
| branchCond | output | 3 | Branch condition code |
| aluOp | output | 4 | ALU operation code |
| src1Mode | output | 3 | First source mode: 0 none, 1 reg, 2 indirect, 3 immediate, 4 low, 5 high, 6 stack pointer |
| src2Mode | output | 3 | Second source mode, same encoding |
| dstMode | output | 3 | Destination mode, same encoding |
| src1Idx | output | 8 | First source register index |
| src2Idx | output | 8 | Second source register index |
| dstIdx | output | 8 | Destination register index |
| immValue | output | 24 | Immediate, zero-extended |
| illegal | output | 1 | Unknown encoding |

## Verification
The block holds no state, so a wrong internal choice appears at the ports in the same cycle the word is applied. A slip in the control table shows as a wrong action or mode, or as the destination taken from the wrong operand field. A slip in the datapath field selection shows as a wrong index or immediate for a valid opcode. Every opcode class is applied with distinct A and B values, so an index taken from the wrong field shows as a mismatch. Undefined encodings are applied at the edges of each opcode range to catch a decode that is too loose.

// File: rtl/instr_decoder_pkg.sv
package instr_decoder_pkg;
  localparam int WordW  = 32;
  localparam int IdxW   = 8;
  localparam int ImmW   = 24;
  localparam int HalfW  = 16;
  localparam int UpperW = WordW - HalfW;

  typedef enum logic [3:0] {
    ACT_NOP = 4'd0, ACT_JUMP = 4'd1, ACT_CALL = 4'd2, ACT_RET = 4'd3,
    ACT_MOVE = 4'd4, ACT_ALU = 4'd5, ACT_PUSH = 4'd6, ACT_POP = 4'd7,
    ACT_HALT = 4'd8
  } actKind_e;

  typedef enum logic [2:0] {
    CND_ALWAYS = 3'd0, CND_ZERO = 3'd1, CND_NZERO = 3'd2,
    CND_CARRY = 3'd3, CND_NCARRY = 3'd4
  } cond_e;

  typedef enum logic [3:0] {
    ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_SHL = 4'd2, ALU_SHR = 4'd3,
    ALU_CMP = 4'd4, ALU_FDIV = 4'd5, ALU_FMUL = 4'd6, ALU_FADD = 4'd7,
    ALU_FSUB = 4'd8, ALU_FSIN = 4'd9, ALU_FCOS = 4'd10, ALU_DEC = 4'd11,
    ALU_INC = 4'd12
  } aluOp_e;

  typedef enum logic [2:0] {
    MD_NONE = 3'd0, MD_REG = 3'd1, MD_IND = 3'd2, MD_IMM = 3'd3,
    MD_LOW = 3'd4, MD_HIGH = 3'd5, MD_SP = 3'd6
  } mode_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0, DST_OPA = 2'd1, DST_OPB = 2'd2, DST_HALFREG = 2'd3
  } dstSel_e;

  typedef enum logic [1:0] {
    IMM_NONE = 2'd0, IMM_WIDE = 2'd1, IMM_HALF = 2'd2
  } immSel_e;

  typedef struct packed {
    actKind_e act;
    cond_e    cond;
    aluOp_e   alu;
    mode_e    m1;
    mode_e    m2;
    mode_e    md;
    logic     useA;
    logic     useB;
    dstSel_e  dsel;
    immSel_e  isel;
    logic     bad;
  } decStrobe_t;
endpackage

// File: rtl/instr_decoder_ctrl.sv
module instr_decoder_ctrl
  import instr_decoder_pkg::*;
(
  input  logic [UpperW-1:0] upperWord,
  output decStrobe_t        strb
);
  logic [2:0]  fmtSel;
  logic [4:0]  shortOp;
  logic [12:0] longOp;
  decStrobe_t  raw;

  assign fmtSel  = upperWord[UpperW-1 -: 3];
  assign shortOp = upperWord[UpperW-4 -: 5];
  assign longOp  = upperWord[UpperW-4:0];

  always_comb begin
    raw = '0;
    unique case (fmtSel)
      3'd0: begin
        unique case (shortOp)
          5'h00: raw.act = ACT_NOP;
          5'h10: raw.act = ACT_RET;
          5'h0F: begin
            raw.act  = ACT_MOVE;
            raw.m1   = MD_IMM;
            raw.md   = MD_SP;
            raw.isel = IMM_WIDE;
          end
          5'h01, 5'h02, 5'h03, 5'h04, 5'h05,
          5'h11, 5'h12, 5'h13, 5'h14, 5'h15: begin
            raw.act  = shortOp[4] ? ACT_CALL : ACT_JUMP;
            raw.cond = cond_e'(shortOp[2:0] - 3'd1);
            raw.m1   = MD_IMM;
            raw.isel = IMM_WIDE;
          end
          default: raw.bad = 1'b1;
        endcase
      end
      3'd1: begin
        unique case (longOp)
          13'h00, 13'h01, 13'h04, 13'h0A, 13'h0B, 13'h0C, 13'h0D: begin
            raw.act  = ACT_ALU;
            raw.m1   = MD_REG;
            raw.m2   = MD_REG;
            raw.md   = MD_REG;
            raw.useA = 1'b1;
            raw.useB = 1'b1;
            raw.dsel = DST_OPB;
            unique case (longOp)
              13'h00:  raw.alu = ALU_ADD;
              13'h01:  raw.alu = ALU_SUB;
              13'h04:  raw.alu = ALU_CMP;
              13'h0A:  raw.alu = ALU_FDIV;
              13'h0B:  raw.alu = ALU_FMUL;
              13'h0C:  raw.alu = ALU_FADD;
              default: raw.alu = ALU_FSUB;
            endcase
          end
          13'h02, 13'h03, 13'h0E, 13'h0F, 13'h10, 13'h11: begin
            raw.act  = ACT_ALU;
            raw.m1   = MD_REG;
            raw.md   = MD_REG;
            raw.useA = 1'b1;
            raw.dsel = DST_OPA;
            unique case (longOp)
              13'h02:  raw.alu = ALU_SHL;
              13'h03:  raw.alu = ALU_SHR;
              13'h0E:  raw.alu = ALU_FSIN;
              13'h0F:  raw.alu = ALU_FCOS;
              13'h10:  raw.alu = ALU_DEC;
              default: raw.alu = ALU_INC;
            endcase
          end
          13'h05: raw.act = ACT_HALT;
          13'h06: begin
            raw.act  = ACT_PUSH;
            raw.m1   = MD_REG;
            raw.useA = 1'b1;
          end
          13'h07: begin
            raw.act  = ACT_POP;
            raw.md   = MD_REG;
            raw.dsel = DST_OPA;
          end
          13'h12: begin
            raw.act  = ACT_MOVE;
            raw.m1   = MD_REG;
            raw.md   = MD_REG;
            raw.useA = 1'b1;
            raw.dsel = DST_OPB;
          end
          13'h08: begin
            raw.act  = ACT_MOVE;
            raw.m1   = MD_REG;
            raw.m2   = MD_IND;
            raw.md   = MD_REG;
            raw.useA = 1'b1;
            raw.useB = 1'b1;
            raw.dsel = DST_OPB;
          end
          13'h09: begin
            raw.act  = ACT_MOVE;
            raw.m1   = MD_REG;
            raw.m2   = MD_REG;
            raw.md   = MD_IND;
            raw.useA = 1'b1;
            raw.useB = 1'b1;
            raw.dsel = DST_OPB;
          end
          default: raw.bad = 1'b1;
        endcase
      end
      3'd2: begin
        if (shortOp == 5'h00 || shortOp == 5'h01) begin
          raw.act  = ACT_MOVE;
          raw.m1   = MD_IMM;
          raw.md   = shortOp[0] ? MD_HIGH : MD_LOW;
          raw.dsel = DST_HALFREG;
          raw.isel = IMM_HALF;
        end else begin
          raw.bad = 1'b1;
        end
      end
      default: raw.bad = 1'b1;
    endcase
  end

  always_comb begin
    strb = raw;
    if (raw.bad) begin
      strb     = '0;
      strb.bad = 1'b1;
    end
  end

  // R2: a control transfer always carries its target as a wide immediate
  always_comb begin
    p_branch_target_r2: assert (!(strb.act == ACT_JUMP || strb.act == ACT_CALL)
                                || (strb.m1 == MD_IMM && strb.isel == IMM_WIDE));
  end
endmodule

// File: rtl/instr_decoder_dp.sv
module instr_decoder_dp
  import instr_decoder_pkg::*;
(
  input  logic [ImmW-1:0] lowerWord,
  input  decStrobe_t      strb,
  output logic [IdxW-1:0] src1Idx,
  output logic [IdxW-1:0] src2Idx,
  output logic [IdxW-1:0] dstIdx,
  output logic [ImmW-1:0] immValue
);
  logic [IdxW-1:0] fieldA;
  logic [IdxW-1:0] fieldB;
  logic [IdxW-1:0] fieldHalfReg;

  assign fieldB       = lowerWord[IdxW-1:0];
  assign fieldA       = lowerWord[2*IdxW-1:IdxW];
  assign fieldHalfReg = lowerWord[ImmW-1:HalfW];

  assign src1Idx = strb.useA ? fieldA : '0;
  assign src2Idx = strb.useB ? fieldB : '0;

  always_comb begin
    unique case (strb.dsel)
      DST_OPA:     dstIdx = fieldA;
      DST_OPB:     dstIdx = fieldB;
      DST_HALFREG: dstIdx = fieldHalfReg;
      default:     dstIdx = '0;
    endcase
  end

  always_comb begin
    unique case (strb.isel)
      IMM_WIDE: immValue = lowerWord;
      IMM_HALF: immValue = {{(ImmW-HalfW){1'b0}}, lowerWord[HalfW-1:0]};
      default:  immValue = '0;
    endcase
  end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import instr_decoder_pkg::*;
(
  input  logic [31:0] instrWord,
  output logic [3:0]  actionKind,
  output logic [2:0]  branchCond,
  output logic [3:0]  aluOp,
  output logic [2:0]  src1Mode,
  output logic [2:0]  src2Mode,
  output logic [2:0]  dstMode,
  output logic [7:0]  src1Idx,
  output logic [7:0]  src2Idx,
  output logic [7:0]  dstIdx,
  output logic [23:0] immValue,
  output logic        illegal
);
  decStrobe_t strb;

  instr_decoder_ctrl u_ctrl (
    .upperWord (instrWord[WordW-1:HalfW]),
    .strb      (strb)
  );

  instr_decoder_dp u_dp (
    .lowerWord (instrWord[ImmW-1:0]),
    .strb      (strb),
    .src1Idx   (src1Idx),
    .src2Idx   (src2Idx),
    .dstIdx    (dstIdx),
    .immValue  (immValue)
  );

  assign actionKind = strb.act;
  assign branchCond = strb.cond;
  assign aluOp      = strb.alu;
  assign src1Mode   = strb.m1;
  assign src2Mode   = strb.m2;
  assign dstMode    = strb.md;
  assign illegal    = strb.bad;

  always_comb begin
    // R8: reserved format codes never decode
    p_bad_format_r8: assert (instrWord[31:29] <= 3'd2 || illegal);
    // R9: an illegal word leaves the datapath outputs quiet
    p_illegal_quiet_r9: assert (!illegal || (immValue == '0 && src1Idx == '0
                                && src2Idx == '0 && dstIdx == '0 && actionKind == 4'd0));
    // R3: every ALU action reads its first source from a register
    p_alu_regsrc_r3: assert (actionKind != 4'd5 || src1Mode == 3'd1);
    // R7: half-word writes carry only a 16-bit immediate
    p_half_imm_r7: assert (!(dstMode == 3'd4 || dstMode == 3'd5) || immValue[23:16] == 8'h00);
  end
endmodule

// File: tb/instr_decoder_test.sv
module instr_decoder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [31:0] instrWord = 32'h0;
  logic [3:0]  actionKind, aluOp;
  logic [2:0]  branchCond, src1Mode, src2Mode, dstMode;
  logic [7:0]  src1Idx, src2Idx, dstIdx;
  logic [23:0] immValue;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  instr_decoder uut (
    .instrWord(instrWord), .actionKind(actionKind), .branchCond(branchCond),
    .aluOp(aluOp), .src1Mode(src1Mode), .src2Mode(src2Mode), .dstMode(dstMode),
    .src1Idx(src1Idx), .src2Idx(src2Idx), .dstIdx(dstIdx),
    .immValue(immValue), .illegal(illegal)
  );

  function automatic logic [68:0] pk(input logic [3:0] a, input logic [2:0] c,
      input logic [3:0] u, input logic [2:0] m1, input logic [2:0] m2,
      input logic [2:0] md, input logic [7:0] i1, input logic [7:0] i2,
      input logic [7:0] id, input logic [23:0] im, input logic il);
    return {a, c, u, m1, m2, md, i1, i2, id, im, il};
  endfunction

  task automatic apply(input string req, input logic [31:0] w, input logic [68:0] exp);
    logic [68:0] act;
    @(negedge clk);
    instrWord = w;
    #1;
    act = {actionKind, branchCond, aluOp, src1Mode, src2Mode, dstMode,
           src1Idx, src2Idx, dstIdx, immValue, illegal};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s word=%h actual=%h expected=%h", req, w, act, exp);
    end
  endtask

  task automatic testIdle();  // R1: the all-zero word is a NOP
    apply("R1", 32'h0000_0000, pk(0,0,0,0,0,0,0,0,0,0,0));
  endtask

  task automatic testFormat0Misc();
    apply("R1", 32'h1000_0000, pk(3,0,0,0,0,0,0,0,0,0,0));
    apply("R1", 32'h0F12_3456, pk(4,0,0,3,0,6,0,0,0,24'h123456,0));
  endtask

  task automatic testBranches();
    apply("R2", 32'h01000100, pk(1,0,0,3,0,0,0,0,0,24'h000100,0));
    apply("R2", 32'h02ABCDEF, pk(1,1,0,3,0,0,0,0,0,24'hABCDEF,0));
    apply("R2", 32'h13FFFFFF, pk(2,2,0,3,0,0,0,0,0,24'hFFFFFF,0));
    apply("R2", 32'h14000004, pk(2,3,0,3,0,0,0,0,0,24'h000004,0));
    apply("R2", 32'h15000010, pk(2,4,0,3,0,0,0,0,0,24'h000010,0));
  endtask

  task automatic testBinaryAlu();
    apply("R3", 32'h20000307, pk(5,0,0,1,1,1,8'h03,8'h07,8'h07,0,0));
    apply("R3", 32'h20011122, pk(5,0,1,1,1,1,8'h11,8'h22,8'h22,0,0));
    apply("R3", 32'h20040102, pk(5,0,4,1,1,1,8'h01,8'h02,8'h02,0,0));
    apply("R3", 32'h200A4050, pk(5,0,5,1,1,1,8'h40,8'h50,8'h50,0,0));
    apply("R3", 32'h200D0A0B, pk(5,0,8,1,1,1,8'h0A,8'h0B,8'h0B,0,0));
  endtask

  task automatic testUnaryAlu();
    apply("R4", 32'h20021105, pk(5,0,2,1,0,1,8'h11,0,8'h11,0,0));
    apply("R4", 32'h20033366, pk(5,0,3,1,0,1,8'h33,0,8'h33,0,0));
    apply("R4", 32'h200F7701, pk(5,0,10,1,0,1,8'h77,0,8'h77,0,0));
    apply("R4", 32'h20112200, pk(5,0,12,1,0,1,8'h22,0,8'h22,0,0));
    apply("R4", 32'h2010AA55, pk(5,0,11,1,0,1,8'hAA,0,8'hAA,0,0));
  endtask

  task automatic testStackHalt();
    apply("R5", 32'h20051234, pk(8,0,0,0,0,0,0,0,0,0,0));
    apply("R5", 32'h20060901, pk(6,0,0,1,0,0,8'h09,0,0,0,0));
    apply("R5", 32'h20070A02, pk(7,0,0,0,0,1,0,0,8'h0A,0,0));
  endtask

  task automatic testMoves();
    apply("R6", 32'h20120304, pk(4,0,0,1,0,1,8'h03,0,8'h04,0,0));
    apply("R6", 32'h20080506, pk(4,0,0,1,2,1,8'h05,8'h06,8'h06,0,0));
    apply("R6", 32'h20090506, pk(4,0,0,1,1,2,8'h05,8'h06,8'h06,0,0));
  endtask

  task automatic testHalfWords();
    apply("R7", 32'h4005BEEF, pk(4,0,0,3,0,4,0,0,8'h05,24'h00BEEF,0));
    apply("R7", 32'h41FF1234, pk(4,0,0,3,0,5,0,0,8'hFF,24'h001234,0));
  endtask

  task automatic testBadFormat();
    apply("R8", 32'h60000000, pk(0,0,0,0,0,0,0,0,0,0,1));
    apply("R8", 32'hE0123456, pk(0,0,0,0,0,0,0,0,0,0,1));
  endtask

  task automatic testBadOpcode();
    apply("R9", 32'h06123456, pk(0,0,0,0,0,0,0,0,0,0,1));
    apply("R9", 32'h16000000, pk(0,0,0,0,0,0,0,0,0,0,1));
    apply("R9", 32'h20130102, pk(0,0,0,0,0,0,0,0,0,0,1));
    apply("R9", 32'h21000102, pk(0,0,0,0,0,0,0,0,0,0,1));
    apply("R9", 32'h42FF1234, pk(0,0,0,0,0,0,0,0,0,0,1));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    testIdle();
    testFormat0Misc();
    testBranches();
    testBinaryAlu();
    testUnaryAlu();
    testStackHalt();
    testMoves();
    testHalfWords();
    testBadFormat();
    testBadOpcode();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule